// File: doc/BRIEF.md
# Received Pulse Width Timer

This block sits between the front end of an infrared-style serial receiver and its receive FIFO. It watches one of two candidate input signals: the filtered line when demodulation is off, or the recovered envelope when it is on. It counts divider ticks between consecutive measuring edges. On every measuring edge that closes an interval it emits a one-cycle write strobe together with an entry. The entry holds the measured tick count and the line level that was present just before the edge.

Software picks which transitions count as measuring edges: rising only, falling only, or both. In demodulated operation every transition counts, whatever the mode setting. If no measuring edge arrives before the count saturates, the block treats the silence as the end of a transmission. It raises a sticky timeout flag and stops counting. The next edge only restarts the measurement.

The FIFO storage and the register interface are outside this block. The write strobe and entry connect straight to a FIFO push port.

Top module: `rxpw_timer`

## Requirements
- R1: While `rst` is high and after it falls, `fifo_wr` and `timeout` are 0 and `fifo_wdata` is 0 until the first write.
- R2: With `demod_en`=0 the timer follows `filt_in` only, and `demod_in` has no effect on the entries. With `demod_en`=1 it follows `demod_in` only, and `filt_in` has no effect.
- R3: `edge_mode` encoding: 2'b00 measures rising edges only, 2'b01 falling edges only, and 2'b10 or 2'b11 both edges. A rising-only entry therefore has bit CNT_W = 0, and a falling-only entry has bit CNT_W = 1.
- R4: With `demod_en`=1, both edges are measuring edges for every value of `edge_mode`.
- R5: An entry is {level before the closing edge in bit CNT_W, tick count in bits CNT_W-1:0}. With `tick_div`=0 the count equals the number of clock cycles between the opening and closing input transitions.
- R6: The first measuring edge after reset, after `rx_en` rises, or after a timeout starts a new interval from zero and produces no write.
- R7: A tick occurs once every `tick_div`+1 clock cycles while enabled. An interval of T cycles therefore counts floor(T/(tick_div+1)) or ceil(T/(tick_div+1)) ticks.
- R8: When the count reaches all ones (2^CNT_W-1) with no closing edge in that tick, `timeout` is set, no entry is written and counting stops. A closing edge that arrives exactly at the all-ones count writes that count instead, and no timeout occurs.
- R9: `timeout` stays set until a cycle with `timeout_clr`=1. While the timer is stopped it cannot be set again until a measuring edge has restarted the count.
- R10: With `rx_en`=0 there are no writes and no timeouts, and the interval is discarded.
- R11: `fifo_wr` is high for exactly one cycle, two clock cycles after the input transition that forms the closing measuring edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive measurement enable |
| demod_en | input | 1 | Selects the demodulated envelope and forces both-edge measurement |
| edge_mode | input | 2 | Measuring edge selection (see R3) |
| tick_div | input | DIV_W | Tick divider reload value; tick period is tick_div+1 cycles |
| filt_in | input | 1 | Filtered line input, already synchronous |
| demod_in | input | 1 | Demodulated envelope input, already synchronous |
| timeout_clr | input | 1 | Clears the timeout flag |
| fifo_wr | output | 1 | One-cycle FIFO write strobe |
| fifo_wdata | output | CNT_W+1 | Entry: level in the top bit, tick count below it |
| timeout | output | 1 | Sticky end-of-transmission flag |

## Verification
The level-bit properties assume that `edge_mode` and `demod_en` change only while `rx_en` is low, so that the configuration seen on the cycle before a write is the one that qualified the edge. The bench changes configuration only between sections, with `rx_en` held low. It also holds both inputs low across each enable, so no stale transition is taken as an opening edge. In every section the unselected input toggles on every cycle, which exercises the input selection continuously without breaking those assumptions.

// File: rtl/rxpw_pkg.sv
package rxpw_pkg;

  // Measuring edge selection
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/rxpw_tick_div.sv
module rxpw_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  localparam logic [DIV_W-1:0] DIV_ZERO = '0;

  logic [DIV_W-1:0] dcnt_q;

  // Down counter: reloads while disabled and on reaching zero
  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q <= DIV_ZERO;
    end else if (!en || (dcnt_q == DIV_ZERO)) begin
      dcnt_q <= div_val;
    end else begin
      dcnt_q <= dcnt_q - 1'b1;
    end
  end

  assign tick = en && (dcnt_q == DIV_ZERO);

endmodule

// File: rtl/rxpw_edge_sel.sv
module rxpw_edge_sel
  import rxpw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       demod_en,
  input  logic [1:0] edge_mode,
  input  logic       filt_in,
  input  logic       demod_in,
  output logic       meas_edge,
  output logic       lvl_before
);

  localparam int LAST = STAGES - 1;

  logic             sel_in;
  logic [LAST:0]    hist_q;
  logic             lvl_new;
  logic             lvl_old;
  logic             is_rise;
  logic             is_fall;
  edge_mode_e       eff_mode;

  assign sel_in = demod_en ? demod_in : filt_in;

  // Input history; the last two stages feed the edge detector
  generate
    if (STAGES < 2) begin : g_bad
      initial $error("STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[LAST-1:0], sel_in};
    end
  end

  assign lvl_new = hist_q[LAST-1];
  assign lvl_old = hist_q[LAST];
  assign is_rise = lvl_new && !lvl_old;
  assign is_fall = !lvl_new && lvl_old;

  // Demodulated envelopes are always measured on both edges
  assign eff_mode = demod_en ? EDGE_BOTH : edge_mode_e'(edge_mode);

  always_comb begin
    unique case (eff_mode)
      EDGE_RISE: meas_edge = en && is_rise;
      EDGE_FALL: meas_edge = en && is_fall;
      default:   meas_edge = en && (is_rise || is_fall);
    endcase
  end

  assign lvl_before = lvl_old;

endmodule

// File: rtl/rxpw_interval_cnt.sv
module rxpw_interval_cnt #(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           tick,
  input  logic           meas_edge,
  input  logic           lvl_before,
  input  logic           clr,
  output logic           wr_stb,
  output logic [CNT_W:0] wr_data,
  output logic           timeout
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             ovf;
  logic             wr_stb_q;
  logic [CNT_W:0]   wr_data_q;
  logic             to_q;

  // Count including this cycle's tick, held at the ceiling
  assign cnt_nx = (run_q && tick && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
  // Saturation without a closing edge ends the transmission
  assign ovf    = en && run_q && !meas_edge && (cnt_nx == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      cnt_q     <= CNT_ZERO;
      wr_stb_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      if (!en) begin
        run_q <= 1'b0;
        cnt_q <= CNT_ZERO;
      end else if (meas_edge) begin
        run_q <= 1'b1;
        cnt_q <= CNT_ZERO;
        if (run_q) begin
          wr_stb_q  <= 1'b1;
          wr_data_q <= {lvl_before, cnt_nx};
        end
      end else if (ovf) begin
        run_q <= 1'b0;
        cnt_q <= CNT_ZERO;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  // Sticky flag: set has priority over the clear request
  always_ff @(posedge clk) begin
    if (rst) begin
      to_q <= 1'b0;
    end else if (ovf) begin
      to_q <= 1'b1;
    end else if (clr) begin
      to_q <= 1'b0;
    end
  end

  assign wr_stb  = wr_stb_q;
  assign wr_data = wr_data_q;
  assign timeout = to_q;

endmodule

// File: rtl/rxpw_timer.sv
module rxpw_timer #(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             demod_en,
  input  logic [1:0]       edge_mode,
  input  logic [DIV_W-1:0] tick_div,
  input  logic             filt_in,
  input  logic             demod_in,
  input  logic             timeout_clr,
  output logic             fifo_wr,
  output logic [CNT_W:0]   fifo_wdata,
  output logic             timeout
);

  logic tick;
  logic meas_edge;
  logic lvl_before;

  rxpw_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_en),
    .div_val (tick_div),
    .tick    (tick)
  );

  rxpw_edge_sel #(.STAGES(STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .demod_en   (demod_en),
    .edge_mode  (edge_mode),
    .filt_in    (filt_in),
    .demod_in   (demod_in),
    .meas_edge  (meas_edge),
    .lvl_before (lvl_before)
  );

  rxpw_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en         (rx_en),
    .tick       (tick),
    .meas_edge  (meas_edge),
    .lvl_before (lvl_before),
    .clr        (timeout_clr),
    .wr_stb     (fifo_wr),
    .wr_data    (fifo_wdata),
    .timeout    (timeout)
  );

endmodule

// File: rtl/rxpw_timer_chk.sv
module rxpw_timer_chk #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             demod_en,
  input logic [1:0]       edge_mode,
  input logic [DIV_W-1:0] tick_div,
  input logic             filt_in,
  input logic             demod_in,
  input logic             timeout_clr,
  input logic             fifo_wr,
  input logic [CNT_W:0]   fifo_wdata,
  input logic             timeout
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!fifo_wr && !timeout));

  // R10
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(rx_en));

  // R8
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> !fifo_wr);

  // R9
  clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(timeout) |-> $past(timeout_clr));

  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && !timeout_clr) |=> timeout);

  // R3
  rise_level_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && $past(rx_en && !demod_en && (edge_mode == 2'b00)))
      |-> !fifo_wdata[CNT_W]);

  // R3
  fall_level_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && $past(rx_en && !demod_en && (edge_mode == 2'b01)))
      |-> fifo_wdata[CNT_W]);

endmodule

bind rxpw_timer rxpw_timer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/rxpw_timer_tb.sv
module rxpw_timer_tb;

  localparam int CW   = 8;
  localparam int DW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_en = 1'b0;
  logic          demod_en = 1'b0;
  logic [1:0]    edge_mode = 2'b10;
  logic [DW-1:0] tick_div = '0;
  logic          filt_in = 1'b0;
  logic          demod_in = 1'b0;
  logic          timeout_clr = 1'b0;
  logic          fifo_wr;
  logic [CW:0]   fifo_wdata;
  logic          timeout;

  always #4 clk = ~clk;

  rxpw_timer #(.CNT_W(CW), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .demod_en(demod_en),
    .edge_mode(edge_mode), .tick_div(tick_div), .filt_in(filt_in),
    .demod_in(demod_in), .timeout_clr(timeout_clr), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .timeout(timeout)
  );

  int checks = 0;
  int fails  = 0;

  // Collected writes
  logic [CW:0] got [0:1023];
  int ng = 0;
  always @(negedge clk) begin
    if (fifo_wr && ng < 1024) begin
      got[ng] = fifo_wdata;
      ng = ng + 1;
    end
  end

  int seg_l [0:63];
  int seg_w [0:63];
  int nseg;
  int exp_l [0:255];
  int exp_w [0:255];
  int nexp;
  int base;
  bit use_demod;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Hold level v on the selected input for n cycles, toggling the other one
  task automatic drive(int v, int n);
    for (int k = 0; k < n; k++) begin
      if (use_demod) begin
        demod_in = v[0];
        filt_in  = ~filt_in;
      end else begin
        filt_in  = v[0];
        demod_in = ~demod_in;
      end
      @(negedge clk);
    end
  endtask

  task automatic start_section(bit dm, logic [1:0] md, int dv);
    @(negedge clk);
    rx_en    = 1'b0;
    filt_in  = 1'b0;
    demod_in = 1'b0;
    demod_en = dm;
    use_demod = dm;
    edge_mode = md;
    tick_div  = dv[DW-1:0];
    timeout_clr = 1'b1;
    wait_n(1);
    timeout_clr = 1'b0;
    wait_n(4);
    rx_en = 1'b1;
    nseg = 0;
    nexp = 0;
    base = ng;
  endtask

  task automatic add_seg(int l, int w);
    seg_l[nseg] = l;
    seg_w[nseg] = w;
    nseg++;
  endtask

  // Drive segments and predict entries; eff: 0 rise, 1 fall, 2 both
  task automatic play(int eff);
    int prev;
    int opened;
    int acc;
    prev = 0; opened = 0; acc = 0;
    for (int i = 0; i < nseg; i++) begin
      if (seg_l[i] != prev) begin
        if (eff == 2 || (eff == 0 && seg_l[i] == 1) || (eff == 1 && seg_l[i] == 0)) begin
          if (opened != 0) begin
            exp_l[nexp] = prev;
            exp_w[nexp] = acc;
            nexp++;
          end
          opened = 1;
          acc = 0;
        end
      end
      prev = seg_l[i];
      acc += seg_w[i];
      drive(seg_l[i], seg_w[i]);
    end
  endtask

  task automatic end_section(string req, int divp);
    int n;
    int c;
    wait_n(8);
    rx_en = 1'b0;
    wait_n(3);
    n = ng - base;
    chk(n == nexp, {req, " entry count"}, n, nexp);
    for (int i = 0; i < nexp && i < n; i++) begin
      c = int'(got[base+i][CW-1:0]);
      chk(int'(got[base+i][CW]) == exp_l[i], {req, " level bit"}, int'(got[base+i][CW]), exp_l[i]);
      if (divp == 1) begin
        chk(c == exp_w[i], {req, " count"}, c, exp_w[i]);
      end else begin
        chk(c == exp_w[i] / divp || c == (exp_w[i] + divp - 1) / divp,
            {req, " divided count"}, c, exp_w[i] / divp);
      end
    end
  endtask

  task automatic push_exp(int l, int w);
    exp_l[nexp] = l;
    exp_w[nexp] = w;
    nexp++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n0;
    use_demod = 1'b0;
    // R1 reset state
    wait_n(3);
    chk(fifo_wr == 1'b0, "R1 wr in reset", int'(fifo_wr), 0);
    chk(timeout == 1'b0, "R1 timeout in reset", int'(timeout), 0);
    chk(fifo_wdata == '0, "R1 data in reset", int'(fifo_wdata), 0);
    rst = 1'b0;
    wait_n(2);
    chk(fifo_wr == 1'b0 && timeout == 1'b0, "R1 after reset", int'(timeout), 0);

    // R3 R5 R6 R2: both edges, widths 1..24
    start_section(1'b0, 2'b10, 0);
    begin
      int lv;
      lv = 0;
      for (int w = 1; w <= 24; w++) begin
        lv = 1 - lv;
        add_seg(lv, w);
      end
      add_seg(1 - lv, 2);
    end
    play(2);
    end_section("R5 both-edge sweep", 1);

    // R3: code 2'b11 also both edges
    start_section(1'b0, 2'b11, 0);
    for (int w = 3; w <= 8; w++) add_seg(w % 2, w);
    add_seg(1, 2);
    play(2);
    end_section("R3 mode 11", 1);

    // R3 rising only
    start_section(1'b0, 2'b00, 0);
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++) begin
        add_seg(1, h);
        add_seg(0, l);
      end
    add_seg(1, 2);
    play(0);
    end_section("R3 rise only", 1);

    // R3 falling only
    start_section(1'b0, 2'b01, 0);
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++) begin
        add_seg(1, h);
        add_seg(0, l);
      end
    add_seg(1, 2);
    add_seg(0, 2);
    play(1);
    end_section("R3 fall only", 1);

    // R4 R2: demod forces both edges even in rise-only mode
    start_section(1'b1, 2'b00, 0);
    for (int w = 2; w <= 12; w++) add_seg((w + 1) % 2, w);
    add_seg(0, 3);
    play(2);
    end_section("R4 demod both edges", 1);

    // R7: divider period 4
    start_section(1'b0, 2'b10, 3);
    for (int w = 8; w <= 20; w++) add_seg(w % 2, w);
    add_seg(1, 3);
    play(2);
    end_section("R7 divider", 4);

    // R8 R9 R6: overflow boundary and timeout handling
    start_section(1'b0, 2'b10, 0);
    drive(1, MAXC);
    push_exp(1, MAXC);
    drive(0, 10);
    chk(timeout == 1'b0, "R8 no timeout at exact max", int'(timeout), 0);
    chk(ng - base == 1, "R8 write at exact max", ng - base, 1);
    drive(0, MAXC + 1 - 10);
    drive(1, 7);
    chk(timeout == 1'b1, "R8 timeout after max+1", int'(timeout), 1);
    chk(ng - base == 1, "R6 R8 no write at overflow or restart", ng - base, 1);
    push_exp(1, 7);
    timeout_clr = 1'b1;
    drive(0, 1);
    timeout_clr = 1'b0;
    drive(0, 2);
    chk(timeout == 1'b0, "R9 cleared", int'(timeout), 0);
    push_exp(0, 3);
    drive(1, 300);
    chk(timeout == 1'b1, "R8 timeout on long level", int'(timeout), 1);
    timeout_clr = 1'b1;
    drive(1, 1);
    timeout_clr = 1'b0;
    drive(1, 300);
    chk(timeout == 1'b0, "R9 no new timeout while parked", int'(timeout), 0);
    drive(0, 4);
    push_exp(0, 4);
    drive(1, 5);
    push_exp(1, 5);
    drive(0, 2);
    end_section("R8 overflow sequence", 1);

    // R11 strobe timing
    start_section(1'b0, 2'b10, 0);
    drive(1, 5);
    filt_in = 1'b0;
    @(negedge clk);
    chk(fifo_wr == 1'b0, "R11 no strobe after one cycle", int'(fifo_wr), 0);
    @(negedge clk);
    chk(fifo_wr == 1'b1, "R11 strobe after two cycles", int'(fifo_wr), 1);
    chk(fifo_wdata == {1'b1, 8'd5}, "R5 R11 strobe data", int'(fifo_wdata), 256 + 5);
    @(negedge clk);
    chk(fifo_wr == 1'b0, "R11 single-cycle strobe", int'(fifo_wr), 0);
    rx_en = 1'b0;
    wait_n(3);

    // R10: disabled timer ignores edges and never times out
    start_section(1'b0, 2'b10, 0);
    rx_en = 1'b0;
    n0 = ng;
    for (int k = 0; k < 20; k++) drive(k % 2, 3);
    drive(0, 300);
    chk(ng == n0, "R10 no writes while disabled", ng - n0, 0);
    chk(timeout == 1'b0, "R10 no timeout while disabled", int'(timeout), 0);

    // R10 R6: disable mid-interval discards it
    start_section(1'b0, 2'b10, 0);
    drive(1, 6);
    rx_en = 1'b0;
    drive(0, 4);
    rx_en = 1'b1;
    drive(0, 3);
    add_seg(1, 5);
    add_seg(0, 2);
    play(2);
    end_section("R10 re-enable restarts", 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule